// File: doc/BRIEF.md
# Center-Aligned Complementary Sine PWM Leg

This block drives one leg of a unipolar full bridge with a pair of complementary, center-aligned pulse trains. A triangular carrier counts up and down between zero and a top value, and moves only on cycles where the clock enable is high. Each carrier period takes one duty value from a 25-step half-sine table. The main output is high while the carrier is above the compare level. The complementary output is high while the carrier is at or below a second level set a fixed number of counts lower. The counts in between form a dead band in which both outputs are low.

A new duty value is fetched when the carrier reaches its top and is held in a shadow stage. It becomes the active compare only when the carrier returns to zero, so a period never mixes two compare levels. Each full pass through the table flips a half-cycle flag. While the flag is set, both outputs of this leg are held low, and the opposite leg of the bridge is expected to carry that half of the sine wave. The outputs and the flag are registered together, so the flag always describes the same carrier state as the outputs next to it.

Top module: `spwm_leg`

## Requirements
- R1: A synchronous active-low reset puts the carrier at 0 counting up, clears the half-cycle flag, restarts the table at step 0 and drives `pwm_main`, `pwm_comp` and `half_phase` low.
- R2: On each cycle with `tick_en` high, the carrier moves one count: up from 0 to TOP (default 199), then down to 0. It never leaves 0..TOP, and one period lasts 2*TOP ticks (398 by default).
- R3: The duty table holds 25 steps: 100, 110, 120, 129, 139, 147, 155, 162, 168, 172, 176, 179, 180, 180, 179, 176, 172, 168, 162, 155, 147, 139, 129, 120, 110. Carrier period k (counted from reset) uses step k mod 25, and its main compare level is that step value minus one.
- R4: `pwm_main` is high exactly for the carrier states above the main compare level. For step value E and the default TOP, that gives 399-2E high ticks per enabled period.
- R5: `pwm_comp` is high exactly for the carrier states at or below the main compare level minus DEAD (default 1), which gives 2E-3 high ticks per enabled period. The two outputs are never high together, and each enabled period has exactly 2*DEAD ticks with both low.
- R6: The next step value is fetched when the carrier reaches TOP and takes effect only when the carrier reaches 0. Every period therefore uses one compare level throughout, and the compare level never changes while the carrier is away from 0.
- R7: The half-cycle flag flips at the start of periods 25, 50, 75 and so on, and is reported on `half_phase`. While `half_phase` is 1, both outputs are low. While it is 0, the outputs follow R4 and R5.
- R8: `pwm_main`, `pwm_comp` and `half_phase` are registers. Each reflects the carrier state from one tick earlier, so the first tick after reset raises `pwm_comp`. While `tick_en` is low, the carrier and all three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Carrier tick enable; the carrier advances one count per high cycle |
| pwm_main | output | 1 | Main switch drive, high around the carrier top |
| pwm_comp | output | 1 | Complementary switch drive, high around the carrier bottom |
| half_phase | output | 1 | Half-cycle flag; 1 means this leg is held off |

## Verification
The main pattern runs the carrier at one tick per cycle for 52 periods. It counts the high ticks of each output in every period, which covers both halves of the sine wave and the return to drive. A per-period count catches a compare level loaded at the top instead of the bottom, because the up and down slopes would then differ. It also catches an off-by-one in the table step, the dead band or the flag toggle. A second pattern ticks only on every other cycle, which shows that the outputs advance with the enable and not with the clock. A held-enable pattern right after reset pins down the one-tick output latency and the reset state.

// File: rtl/spwm_pkg.sv
// spwm_pkg: types and the half-sine duty table shared by the SPWM leg.
// Assumes the table values fit in ENTRY_W bits and stay below the carrier top.
package spwm_pkg;

    localparam int STEPS   = 25;
    localparam int ENTRY_W = 8;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Half-sine duty value for table step k (0 .. STEPS-1).
    function automatic logic [ENTRY_W-1:0] sine_step(input logic [4:0] k);
        logic [ENTRY_W-1:0] v;
        case (k)
            5'd0:  v = 8'd100;
            5'd1:  v = 8'd110;
            5'd2:  v = 8'd120;
            5'd3:  v = 8'd129;
            5'd4:  v = 8'd139;
            5'd5:  v = 8'd147;
            5'd6:  v = 8'd155;
            5'd7:  v = 8'd162;
            5'd8:  v = 8'd168;
            5'd9:  v = 8'd172;
            5'd10: v = 8'd176;
            5'd11: v = 8'd179;
            5'd12: v = 8'd180;
            5'd13: v = 8'd180;
            5'd14: v = 8'd179;
            5'd15: v = 8'd176;
            5'd16: v = 8'd172;
            5'd17: v = 8'd168;
            5'd18: v = 8'd162;
            5'd19: v = 8'd155;
            5'd20: v = 8'd147;
            5'd21: v = 8'd139;
            5'd22: v = 8'd129;
            5'd23: v = 8'd120;
            5'd24: v = 8'd110;
            default: v = 8'd100;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/spwm_carrier.sv
// spwm_carrier: up/down triangular carrier between 0 and TOP.
// Moves one count per cycle with tick_en high. It flags the tick that lands
// on TOP and the tick that lands on 0, so the duty sequencer can act on them.
// Assumes TOP >= 2.
module spwm_carrier #(
    parameter int TOP = 199,
    parameter int CW  = $clog2(TOP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    output logic [CW-1:0] cnt,
    output logic          at_top,
    output logic          at_bottom
);
    import spwm_pkg::*;

    logic [CW-1:0] cnt_q;
    dir_e          dir_q;

    // Decode the ticks that reach either end of the ramp.
    always_comb begin
        at_top    = tick_en && (dir_q == DIR_UP)   && (cnt_q == CW'(TOP - 1));
        at_bottom = tick_en && (dir_q == DIR_DOWN) && (cnt_q == CW'(1));
    end

    // Step the count and turn around at the ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (tick_en) begin
            if (dir_q == DIR_UP) begin
                cnt_q <= cnt_q + CW'(1);
                if (at_top) begin
                    dir_q <= DIR_DOWN;
                end
            end else begin
                cnt_q <= cnt_q - CW'(1);
                if (at_bottom) begin
                    dir_q <= DIR_UP;
                end
            end
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/spwm_duty_seq.sv
// spwm_duty_seq: walks the half-sine table and owns both compare levels.
// At the top tick, it fetches the next step into a shadow stage. At the
// bottom tick, it copies the shadow into the active levels and the active
// half-cycle flag. The flag in the shadow flips whenever step 0 is fetched
// again, which marks the start of the next half sine wave.
// Assumes DEAD < smallest table value - 1.
module spwm_duty_seq #(
    parameter int CW   = 8,
    parameter int DEAD = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          at_top,
    input  logic          at_bottom,
    output logic [CW-1:0] cmp_main,
    output logic [CW-1:0] cmp_comp,
    output logic          phase
);
    import spwm_pkg::*;

    localparam int IW = $clog2(STEPS);

    logic [IW-1:0]      idx_q;
    logic [ENTRY_W-1:0] shadow_q;
    logic               shadow_phase_q;
    logic [CW-1:0]      act_main_q;
    logic [CW-1:0]      act_comp_q;
    logic               act_phase_q;
    logic [ENTRY_W-1:0] fetch;
    logic [CW-1:0]      shadow_main;

    // Table value at the fetch pointer and the compare level it implies.
    always_comb begin
        fetch       = sine_step(5'(idx_q));
        shadow_main = CW'(shadow_q) - CW'(1);
    end

    // Fetch at the top; advance and wrap the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q          <= IW'(1);
            shadow_q       <= sine_step(5'd0);
            shadow_phase_q <= 1'b0;
        end else if (at_top) begin
            shadow_q <= fetch;
            if (idx_q == '0) begin
                shadow_phase_q <= ~shadow_phase_q;
            end
            if (idx_q == IW'(STEPS - 1)) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    // Commit the shadow to the active levels only at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_main_q  <= CW'(sine_step(5'd0)) - CW'(1);
            act_comp_q  <= CW'(sine_step(5'd0)) - CW'(1) - CW'(DEAD);
            act_phase_q <= 1'b0;
        end else if (at_bottom) begin
            act_main_q  <= shadow_main;
            act_comp_q  <= shadow_main - CW'(DEAD);
            act_phase_q <= shadow_phase_q;
        end
    end

    assign cmp_main = act_main_q;
    assign cmp_comp = act_comp_q;
    assign phase    = act_phase_q;

endmodule

// File: rtl/spwm_out_stage.sv
// spwm_out_stage: registered output drivers.
// On each tick, it registers the main and complementary levels and the
// half-cycle flag from the same carrier state, one tick behind. Both drives
// are forced low while the flag is set.
module spwm_out_stage #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp_main,
    input  logic [CW-1:0] cmp_comp,
    input  logic          phase,
    output logic          pwm_main,
    output logic          pwm_comp,
    output logic          half_phase
);
    logic main_d;
    logic comp_d;

    // Level compares; the gap between the two levels is the dead band.
    always_comb begin
        main_d = !phase && (cnt > cmp_main);
        comp_d = !phase && (cnt <= cmp_comp);
    end

    // Register the drives and the flag together so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_main   <= 1'b0;
            pwm_comp   <= 1'b0;
            half_phase <= 1'b0;
        end else if (tick_en) begin
            pwm_main   <= main_d;
            pwm_comp   <= comp_d;
            half_phase <= phase;
        end
    end

endmodule

// File: rtl/spwm_leg.sv
// spwm_leg: complementary center-aligned sine PWM for one bridge leg.
// Joins the carrier, the duty sequencer and the output stage.
// Assumes TOP exceeds the largest table value.
module spwm_leg #(
    parameter int TOP  = 199,
    parameter int DEAD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic pwm_main,
    output logic pwm_comp,
    output logic half_phase
);
    localparam int CW = $clog2(TOP + 1);

    logic [CW-1:0] cnt_w;
    logic          at_top_w;
    logic          at_bottom_w;
    logic [CW-1:0] cmp_main_w;
    logic [CW-1:0] cmp_comp_w;
    logic          phase_w;

    spwm_carrier #(.TOP(TOP), .CW(CW)) u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt       (cnt_w),
        .at_top    (at_top_w),
        .at_bottom (at_bottom_w)
    );

    spwm_duty_seq #(.CW(CW), .DEAD(DEAD)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_top    (at_top_w),
        .at_bottom (at_bottom_w),
        .cmp_main  (cmp_main_w),
        .cmp_comp  (cmp_comp_w),
        .phase     (phase_w)
    );

    spwm_out_stage #(.CW(CW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .cnt        (cnt_w),
        .cmp_main   (cmp_main_w),
        .cmp_comp   (cmp_comp_w),
        .phase      (phase_w),
        .pwm_main   (pwm_main),
        .pwm_comp   (pwm_comp),
        .half_phase (half_phase)
    );

endmodule

// File: rtl/spwm_leg_chk.sv
// spwm_leg_chk: temporal checks on the SPWM leg, attached by bind.
// Watches the ports, the carrier count and the active main compare level.
module spwm_leg_chk #(
    parameter int TOP = 199
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_en,
    input logic                       pwm_main,
    input logic                       pwm_comp,
    input logic                       half_phase,
    input logic [$clog2(TOP + 1)-1:0] cnt,
    input logic [$clog2(TOP + 1)-1:0] cmp_main
);
    // R2: the carrier stays inside its ramp.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= TOP);

    // R2: each tick moves the carrier by exactly one count.
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> ((int'(cnt) == int'($past(cnt)) + 1) ||
                     (int'(cnt) == int'($past(cnt)) - 1)));

    // R5: the two drives are never high together.
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_main && pwm_comp));

    // R6: the active compare level changes only as the carrier lands on 0.
    p_cmp_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_main) |-> (cnt == '0));

    // R7: a leg in its off half drives nothing.
    p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        half_phase |-> (!pwm_main && !pwm_comp));

    // R8: with no tick, the carrier and the drives hold.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(cnt) && $stable(pwm_main) &&
                      $stable(pwm_comp) && $stable(half_phase)));

endmodule

bind spwm_leg spwm_leg_chk #(.TOP(TOP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .pwm_main   (pwm_main),
    .pwm_comp   (pwm_comp),
    .half_phase (half_phase),
    .cnt        (cnt_w),
    .cmp_main   (cmp_main_w)
);

// File: tb/spwm_leg_tb.sv
// spwm_leg_tb: self-checking bench for the SPWM leg at default parameters.
module spwm_leg_tb;

    localparam int TOP  = 199;
    localparam int PER  = 2 * TOP;
    localparam int NPER = 52;
    localparam int NVEC = 12;

    // {period, expected half_phase, main high ticks, comp high ticks}
    localparam int VEC [NVEC][4] = '{
        '{0,  0, 199, 197},
        '{1,  0, 179, 217},
        '{2,  0, 159, 237},
        '{10, 0, 47,  349},
        '{12, 0, 39,  357},
        '{13, 0, 39,  357},
        '{24, 0, 179, 217},
        '{25, 1, 0,   0},
        '{37, 1, 0,   0},
        '{49, 1, 0,   0},
        '{50, 0, 199, 197},
        '{51, 0, 179, 217}
    };

    logic clk      = 1'b0;
    logic rst_n    = 1'b0;
    logic tick_en  = 1'b0;
    logic pwm_main;
    logic pwm_comp;
    logic half_phase;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    spwm_leg u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .pwm_main   (pwm_main),
        .pwm_comp   (pwm_comp),
        .half_phase (half_phase)
    );

    function automatic int step_val(input int k);
        case (k)
            0: return 100;   1: return 110;   2: return 120;   3: return 129;
            4: return 139;   5: return 147;   6: return 155;   7: return 162;
            8: return 168;   9: return 172;   10: return 176;  11: return 179;
            12: return 180;  13: return 180;  14: return 179;  15: return 176;
            16: return 172;  17: return 168;  18: return 162;  19: return 155;
            20: return 147;  21: return 139;  22: return 129;  23: return 120;
            default: return 110;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int ca, cb, cboth, ph, first_a, e, exp_a, exp_b;
        bit on;

        // R1 / R8: reset state, then hold with no tick.
        do_reset();
        repeat (20) @(negedge clk);
        chk("R1 main low after reset", int'(pwm_main), 0);
        chk("R1 comp low after reset", int'(pwm_comp), 0);
        chk("R1 half_phase low after reset", int'(half_phase), 0);
        chk("R8 no tick keeps comp low", int'(pwm_comp), 0);
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        chk("R8 first tick raises comp", int'(pwm_comp), 1);
        chk("R8 first tick keeps main low", int'(pwm_main), 0);
        repeat (5) @(negedge clk);
        chk("R8 comp held without tick", int'(pwm_comp), 1);

        // Main pattern: one tick per cycle, 52 periods, vector table walk.
        do_reset();
        tick_en = 1'b1;
        for (int k = 0; k < NPER; k++) begin
            ca = 0; cb = 0; cboth = 0; ph = -1; first_a = -1;
            for (int s = 0; s < PER; s++) begin
                @(posedge clk);
                @(negedge clk);
                ca += int'(pwm_main);
                cb += int'(pwm_comp);
                cboth += int'(!pwm_main && !pwm_comp);
                if (pwm_main && pwm_comp) cboth = -10000;
                if (s == PER / 2) ph = int'(half_phase);
                if (pwm_main && first_a < 0) first_a = s;
            end
            on    = ((k / 25) % 2) == 0;
            e     = step_val(k % 25);
            exp_a = on ? 399 - 2 * e : 0;
            exp_b = on ? 2 * e - 3 : 0;
            chk($sformatf("R3 R4 main ticks period %0d", k), ca, exp_a);
            chk($sformatf("R3 R5 comp ticks period %0d", k), cb, exp_b);
            chk($sformatf("R5 dead ticks period %0d", k), cboth, on ? 2 : PER);
            chk($sformatf("R7 half_phase period %0d", k), ph, on ? 0 : 1);
            if (k == 0) chk("R2 R4 main first high sample", first_a, 100);
            for (int v = 0; v < NVEC; v++) begin
                if (VEC[v][0] == k) begin
                    chk($sformatf("R7 vector phase period %0d", k), ph, VEC[v][1]);
                    chk($sformatf("R6 vector main period %0d", k), ca, VEC[v][2]);
                    chk($sformatf("R6 vector comp period %0d", k), cb, VEC[v][3]);
                end
            end
        end

        // R1: reset in the middle of a run clears all outputs.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid-run reset main", int'(pwm_main), 0);
        chk("R1 mid-run reset comp", int'(pwm_comp), 0);
        chk("R1 mid-run reset half_phase", int'(half_phase), 0);

        // R8 / R2: tick on every other cycle, one carrier period of ticks.
        do_reset();
        ca = 0; cb = 0;
        for (int c = 0; c < 2 * PER; c++) begin
            tick_en = (c % 2) == 0;
            @(posedge clk);
            @(negedge clk);
            ca += int'(pwm_main);
            cb += int'(pwm_comp);
        end
        tick_en = 1'b0;
        chk("R8 half-rate main samples", ca, 2 * 199);
        chk("R8 half-rate comp samples", cb, 2 * 197);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule